// File: doc/BRIEF.md
# Dual-Access Debug Flag and Buffer Register

This block sits between a processor's peripheral register bus and the system-programming buffer of a JTAG test access port. It holds two registers, selected by a single select line. The flag register reports a programming-source field, a program-enable bit and a transfer-complete flag. The debug buffer is the parallel holding register for the TAP debug shift register.

The source field and the enable bit each have two copies. One copy is written by the processor and the other is loaded from the JTAG side. A processor read returns the OR of the two copies, and the merged values also drive the block's outputs. These outputs tell the boot logic whether to run in-system programming and which interface to use. Any processor write to the flag register wipes the JTAG copy of the source field. A ROD strobe drops the JTAG copy of the enable bit. Power-on reset clears everything. Test-Logic-Reset clears only the two copies of the source field and the enable bit.

Top module: `dbg_flag_regs`

## Requirements
- R1: With `cpu_sel`=0 the read data is the flag register: bit 0 is the transfer-complete flag, bit 1 is program-enable, bits 3:2 are the source field, and bits 7:4 always read 0, whatever was written to them. With `cpu_sel`=1 the read data is the debug buffer. Reads are combinational.
- R2: The source field read, and the `src_sel` output, are the bitwise OR of the processor copy and the JTAG copy. The encoding is 00 JTAG, 01 UART, 10 SPI and 11 reserved. The field is meaningful only while program-enable reads 1.
- R3: The program-enable read, and the `boot_isp` output, are the OR of the processor copy and the JTAG copy.
- R4: Any processor write to the flag register clears the JTAG source copy at that clock edge. This holds even if a JTAG update lands in the same cycle. The processor source copy and enable copy load from write data bits 3:2 and 1.
- R5: A JTAG update (`jt_upd`) loads the JTAG source copy from `jt_src` and the JTAG enable copy from `jt_pen`. When `jt_buf_ld` is also high, it loads the debug buffer from `jt_shift`. When `jt_buf_ld` is low, the buffer is left unchanged.
- R6: `rod` clears the JTAG enable copy and leaves the processor enable copy unchanged. `rod` wins over a JTAG update in the same cycle.
- R7: `tlr` clears both copies of the source field and of the enable bit. It leaves the transfer-complete flag and the debug buffer unchanged.
- R8: `por_n` low asynchronously clears both registers and all copies, so every read and every output is 0.
- R9: `xfer_done` sets the transfer-complete flag. A processor flag write loads the flag from write data bit 0. When both happen in the same cycle, the flag becomes 1.
- R10: A processor write with `cpu_sel`=1 loads the debug buffer, which appears on `buf_q`. A JTAG buffer load in the same cycle takes priority. A buffer write leaves the flag register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tlr | input | 1 | Test-Logic-Reset pulse, synchronous |
| cpu_sel | input | 1 | Register select: 0 flag, 1 debug buffer |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data of the selected register |
| jt_upd | input | 1 | JTAG update strobe |
| jt_src | input | 2 | JTAG source field value |
| jt_pen | input | 1 | JTAG program-enable value |
| jt_buf_ld | input | 1 | With `jt_upd`, load the buffer from the shift register |
| jt_shift | input | 8 | Parallel shift-register contents |
| xfer_done | input | 1 | End of a TAP transfer cycle |
| rod | input | 1 | Strobe that clears the JTAG enable copy |
| buf_q | output | 8 | Debug buffer contents toward the shift register |
| src_sel | output | 2 | Merged programming source |
| boot_isp | output | 1 | Merged program-enable |

## Verification
The bench builds the block with the default 8-bit data width. At this width the whole two-copy space can be swept: 4 processor source values, 2 processor enable values, 4 JTAG source values and 2 JTAG enable values, 64 combinations in all. Each combination is checked against an OR computed arithmetically in the bench. Every one of the 256 buffer values is written and read back. The same-cycle collisions are driven directly: processor write against JTAG update, `rod` against update, hardware flag set against processor write, and JTAG buffer load against processor buffer write.

// File: rtl/dbg_flag_pkg.sv
package dbg_flag_pkg;
  localparam int SRC_W    = 2;
  localparam int BIT_TXC  = 0;
  localparam int BIT_PEN  = 1;
  localparam int SRC_LO   = 2;
  localparam int FLAG_USED = SRC_LO + SRC_W;

  typedef enum logic [SRC_W-1:0] {
    SRC_JTAG = 2'b00,
    SRC_UART = 2'b01,
    SRC_SPI  = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  // Merge of a processor copy and a JTAG copy of a control field.
  function automatic logic [SRC_W-1:0] merge_src(input logic [SRC_W-1:0] a,
                                                 input logic [SRC_W-1:0] b);
    return a | b;
  endfunction

  function automatic logic merge_bit(input logic a, input logic b);
    return a | b;
  endfunction

  // Packs the used low part of the flag register.
  function automatic logic [FLAG_USED-1:0] pack_flag(input logic [SRC_W-1:0] src,
                                                     input logic pen,
                                                     input logic txc);
    return {src, pen, txc};
  endfunction
endpackage

// File: rtl/dbg_ctl_copies.sv
module dbg_ctl_copies
  import dbg_flag_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             tlr,
  input  logic             flag_wr,
  input  logic [SRC_W-1:0] wr_src,
  input  logic             wr_pen,
  input  logic             jt_upd,
  input  logic [SRC_W-1:0] jt_src,
  input  logic             jt_pen,
  input  logic             rod,
  output logic [SRC_W-1:0] cpu_src_q,
  output logic             cpu_pen_q,
  output logic [SRC_W-1:0] jt_src_q,
  output logic             jt_pen_q
);
  // Named events for the assertions
  logic jsrc_wipe, jsrc_load, jpen_drop, jpen_load;
  assign jsrc_wipe = flag_wr;
  assign jsrc_load = jt_upd & ~flag_wr;
  assign jpen_drop = rod;
  assign jpen_load = jt_upd & ~rod;

  // Processor copies
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cpu_src_q <= '0;
      cpu_pen_q <= 1'b0;
    end else if (tlr) begin
      cpu_src_q <= '0;
      cpu_pen_q <= 1'b0;
    end else if (flag_wr) begin
      cpu_src_q <= wr_src;
      cpu_pen_q <= wr_pen;
    end
  end

  // JTAG source copy
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         jt_src_q <= '0;
    else if (tlr)       jt_src_q <= '0;
    else if (jsrc_wipe) jt_src_q <= '0;
    else if (jsrc_load) jt_src_q <= jt_src;
  end

  // JTAG enable copy
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         jt_pen_q <= 1'b0;
    else if (tlr)       jt_pen_q <= 1'b0;
    else if (jpen_drop) jt_pen_q <= 1'b0;
    else if (jpen_load) jt_pen_q <= jt_pen;
  end

  p_cpu_wr_wipes_jsrc_r4: assert property (@(posedge clk) disable iff (!por_n)
    flag_wr |=> (jt_src_q == '0));

  p_cpu_wr_loads_copy_r4: assert property (@(posedge clk) disable iff (!por_n)
    (flag_wr && !tlr) |=> (cpu_src_q == $past(wr_src) && cpu_pen_q == $past(wr_pen)));

  p_jt_upd_loads_r5: assert property (@(posedge clk) disable iff (!por_n)
    (jt_upd && !tlr && !flag_wr && !rod) |=>
      (jt_src_q == $past(jt_src) && jt_pen_q == $past(jt_pen)));

  p_rod_drops_jpen_r6: assert property (@(posedge clk) disable iff (!por_n)
    rod |=> !jt_pen_q);

  p_rod_keeps_cpu_pen_r6: assert property (@(posedge clk) disable iff (!por_n)
    (rod && !tlr && !flag_wr) |=> $stable(cpu_pen_q));

  p_tlr_clears_r7: assert property (@(posedge clk) disable iff (!por_n)
    tlr |=> (cpu_src_q == '0 && jt_src_q == '0 && !cpu_pen_q && !jt_pen_q));
endmodule

// File: rtl/dbg_xfer_flag.sv
module dbg_xfer_flag (
  input  logic clk,
  input  logic por_n,
  input  logic xfer_done,
  input  logic flag_wr,
  input  logic wr_bit,
  output logic txc_q
);
  logic hw_set, sw_load;
  assign hw_set  = xfer_done;
  assign sw_load = flag_wr & ~xfer_done;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       txc_q <= 1'b0;
    else if (hw_set)  txc_q <= 1'b1;
    else if (sw_load) txc_q <= wr_bit;
  end

  p_hw_set_wins_r9: assert property (@(posedge clk) disable iff (!por_n)
    xfer_done |=> txc_q);

  p_sw_load_r9: assert property (@(posedge clk) disable iff (!por_n)
    (flag_wr && !xfer_done) |=> (txc_q == $past(wr_bit)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!flag_wr && !xfer_done) |=> $stable(txc_q));
endmodule

// File: rtl/dbg_data_buf.sv
module dbg_data_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cpu_ld,
  input  logic [DATA_W-1:0] cpu_d,
  input  logic              jt_ld,
  input  logic [DATA_W-1:0] jt_d,
  output logic [DATA_W-1:0] q
);
  logic cpu_take;
  assign cpu_take = cpu_ld & ~jt_ld;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        q <= '0;
    else if (jt_ld)    q <= jt_d;
    else if (cpu_take) q <= cpu_d;
  end

  p_jt_ld_prio_r10: assert property (@(posedge clk) disable iff (!por_n)
    jt_ld |=> (q == $past(jt_d)));

  p_cpu_ld_r10: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_ld && !jt_ld) |=> (q == $past(cpu_d)));

  p_buf_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!cpu_ld && !jt_ld) |=> $stable(q));
endmodule

// File: rtl/dbg_flag_regs.sv
module dbg_flag_regs
  import dbg_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              tlr,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              jt_upd,
  input  logic [SRC_W-1:0]  jt_src,
  input  logic              jt_pen,
  input  logic              jt_buf_ld,
  input  logic [DATA_W-1:0] jt_shift,
  input  logic              xfer_done,
  input  logic              rod,
  output logic [DATA_W-1:0] buf_q,
  output logic [SRC_W-1:0]  src_sel,
  output logic              boot_isp
);
  localparam int RSVD_W = DATA_W - FLAG_USED;

  // Decoded events
  logic flag_wr, buf_wr, jt_buf_load;
  assign flag_wr     = cpu_wr & ~cpu_sel;
  assign buf_wr      = cpu_wr &  cpu_sel;
  assign jt_buf_load = jt_upd & jt_buf_ld;

  logic [SRC_W-1:0] cpu_src_q, jt_src_q;
  logic             cpu_pen_q, jt_pen_q, txc_q;

  dbg_ctl_copies u_ctl (
    .clk       (clk),
    .por_n     (por_n),
    .tlr       (tlr),
    .flag_wr   (flag_wr),
    .wr_src    (cpu_wdata[SRC_LO +: SRC_W]),
    .wr_pen    (cpu_wdata[BIT_PEN]),
    .jt_upd    (jt_upd),
    .jt_src    (jt_src),
    .jt_pen    (jt_pen),
    .rod       (rod),
    .cpu_src_q (cpu_src_q),
    .cpu_pen_q (cpu_pen_q),
    .jt_src_q  (jt_src_q),
    .jt_pen_q  (jt_pen_q)
  );

  dbg_xfer_flag u_txc (
    .clk       (clk),
    .por_n     (por_n),
    .xfer_done (xfer_done),
    .flag_wr   (flag_wr),
    .wr_bit    (cpu_wdata[BIT_TXC]),
    .txc_q     (txc_q)
  );

  dbg_data_buf #(.DATA_W(DATA_W)) u_buf (
    .clk    (clk),
    .por_n  (por_n),
    .cpu_ld (buf_wr),
    .cpu_d  (cpu_wdata),
    .jt_ld  (jt_buf_load),
    .jt_d   (jt_shift),
    .q      (buf_q)
  );

  // Merged view
  logic [FLAG_USED-1:0] flag_used;
  logic [DATA_W-1:0]    flag_view;
  assign src_sel   = merge_src(cpu_src_q, jt_src_q);
  assign boot_isp  = merge_bit(cpu_pen_q, jt_pen_q);
  assign flag_used = pack_flag(src_sel, boot_isp, txc_q);

  generate
    if (RSVD_W > 0) begin : g_pad
      assign flag_view = {{RSVD_W{1'b0}}, flag_used};
    end else begin : g_nopad
      assign flag_view = flag_used[DATA_W-1:0];
    end
  endgenerate

  assign cpu_rdata = cpu_sel ? buf_q : flag_view;

  p_buf_wr_keeps_flag_r10: assert property (@(posedge clk) disable iff (!por_n)
    (buf_wr && !tlr && !xfer_done && !jt_upd && !rod) |=> $stable(flag_used));
endmodule

// File: tb/sim_dbg_flag_regs.sv
module sim_dbg_flag_regs;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, tlr = 1'b0;
  logic       cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic       jt_upd = 1'b0, jt_pen = 1'b0, jt_buf_ld = 1'b0;
  logic [1:0] jt_src = '0, src_sel;
  logic [7:0] jt_shift = '0, buf_q;
  logic       xfer_done = 1'b0, rod = 1'b0, boot_isp;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_flag_regs #(.DATA_W(8)) u0 (
    .clk(clk), .por_n(por_n), .tlr(tlr), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .jt_upd(jt_upd), .jt_src(jt_src),
    .jt_pen(jt_pen), .jt_buf_ld(jt_buf_ld), .jt_shift(jt_shift),
    .xfer_done(xfer_done), .rod(rod), .buf_q(buf_q), .src_sel(src_sel),
    .boot_isp(boot_isp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected flag value: source OR in bits 3:2, enable OR in bit 1, flag in bit 0
  function automatic int exp_flag(int cs, int cp, int js, int jp, int t);
    return (cs | js) * 4 + (cp | jp) * 2 + t;
  endfunction

  task automatic step();
    @(negedge clk);
    cpu_wr = 0; jt_upd = 0; jt_buf_ld = 0; tlr = 0; rod = 0; xfer_done = 0;
  endtask

  task automatic cpu_write(input logic sel, input logic [7:0] d);
    cpu_sel = sel; cpu_wdata = d; cpu_wr = 1; step();
  endtask

  task automatic jtag_update(input int s, input int p, input logic ld, input logic [7:0] sh);
    jt_src = s[1:0]; jt_pen = p[0]; jt_buf_ld = ld; jt_shift = sh; jt_upd = 1; step();
  endtask

  task automatic rd(input logic sel, output int v);
    cpu_sel = sel; #1; v = int'(cpu_rdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    // R8 reset state
    rd(0, v); chk("R8 flag after reset", v, 0);
    rd(1, v); chk("R8 buffer after reset", v, 0);
    chk("R8 boot_isp after reset", int'(boot_isp), 0);

    // R1 R2 R3 R5 sweep of all copy combinations
    for (int cs = 0; cs < 4; cs++)
      for (int cp = 0; cp < 2; cp++)
        for (int js = 0; js < 4; js++)
          for (int jp = 0; jp < 2; jp++) begin
            tlr = 1; step();
            cpu_write(0, 8'(8'hF0 + cs * 4 + cp * 2));
            jtag_update(js, jp, 0, 8'h00);
            rd(0, v);
            chk("R1/R2/R3 merged flag read", v, exp_flag(cs, cp, js, jp, 0));
            chk("R2 src_sel output", int'(src_sel), cs | js);
            chk("R3 boot_isp output", int'(boot_isp), cp | jp);
          end

    // R4 processor write wipes JTAG source copy
    tlr = 1; step();
    jtag_update(3, 0, 0, 8'h00);
    cpu_write(0, 8'h00);
    rd(0, v); chk("R4 write wipes jtag src", v, 0);
    // same-cycle write and update: src wiped, enable still loaded
    cpu_sel = 0; cpu_wdata = 8'h04; cpu_wr = 1;
    jt_src = 2'b10; jt_pen = 1; jt_upd = 1; step();
    rd(0, v); chk("R4 write beats update on src", v, exp_flag(1, 0, 0, 1, 0));

    // R6 rod
    tlr = 1; step();
    cpu_write(0, 8'h02);
    jtag_update(0, 1, 0, 8'h00);
    rod = 1; step();
    chk("R6 rod keeps cpu enable", int'(boot_isp), 1);
    cpu_write(0, 8'h00);
    chk("R6 rod dropped jtag enable", int'(boot_isp), 0);
    jt_src = 0; jt_pen = 1; jt_upd = 1; rod = 1; step();
    chk("R6 rod beats update", int'(boot_isp), 0);

    // R7 tlr
    cpu_write(0, 8'h0F);
    jtag_update(2, 1, 0, 8'h00);
    cpu_write(1, 8'hA5);
    tlr = 1; step();
    rd(0, v); chk("R7 tlr keeps txc clears copies", v, 1);
    rd(1, v); chk("R7 tlr keeps buffer", v, 8'hA5);

    // R9 transfer-complete flag
    cpu_write(0, 8'h00);
    rd(0, v); chk("R9 sw clear", v, 0);
    xfer_done = 1; step();
    rd(0, v); chk("R9 hw set", v, 1);
    cpu_write(0, 8'h00);
    cpu_sel = 0; cpu_wdata = 8'h00; cpu_wr = 1; xfer_done = 1; step();
    rd(0, v); chk("R9 hw set beats write", v, 1);
    cpu_write(0, 8'h00);
    cpu_write(0, 8'h01);
    rd(0, v); chk("R9 sw set", v, 1);
    cpu_write(0, 8'h00);

    // R10 buffer sweep
    for (int b = 0; b < 256; b++) begin
      cpu_write(1, 8'(b));
      rd(1, v); chk("R10 buffer write/read", v, b);
      chk("R10 buf_q output", int'(buf_q), b);
    end
    cpu_write(0, 8'h06);
    cpu_write(1, 8'h5A);
    rd(0, v); chk("R10 buffer write leaves flag", v, 6);
    cpu_sel = 1; cpu_wdata = 8'hC3; cpu_wr = 1;
    jt_src = 0; jt_pen = 0; jt_buf_ld = 1; jt_shift = 8'h3C; jt_upd = 1; step();
    rd(1, v); chk("R10 jtag load beats cpu write", v, 8'h3C);
    jtag_update(0, 0, 0, 8'h99);
    rd(1, v); chk("R5 update without load keeps buffer", v, 8'h3C);
    jtag_update(0, 0, 1, 8'h81);
    rd(1, v); chk("R5 update with load", v, 8'h81);

    // R8 power-on reset mid-run
    cpu_write(0, 8'h0F);
    jtag_update(1, 1, 0, 8'h00);
    #3 por_n = 0; #2;
    rd(0, v); chk("R8 por clears flag", v, 0);
    rd(1, v); chk("R8 por clears buffer", v, 0);
    chk("R8 por clears src_sel", int'(src_sel), 0);
    @(negedge clk); por_n = 1; @(negedge clk);
    rd(0, v); chk("R8 flag stays clear", v, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule